// File: doc/BRIEF.md
# JTAG Debug Command Decoder

This block sits behind a TAP controller and turns data-register scans into debug actions. Bits arrive on `tdi` one per `tck` while `shift_en` is high, least significant bit first, so the last bit of a scan is its most significant bit. When `update_en` pulses, the block decodes what was shifted in. A short scan whose top bit is 1 picks one of four debug modules. Any other scan is a command for the module already picked. Commands select an internal register, write an internal register, read the selected register, or start a burst read or write described by a packed word count, start address and word size.

The block keeps the active module, one internal-register index for each module, and the last burst descriptor and register-write payload. It raises one-cycle strobes that tell the bus master or the CPU debug port what to do. Register contents that a read command fetches are loaded from `rd_data` and shifted out on `tdo` during the following scan. The scan tracker is a three-state machine. SC_IDLE goes to SC_SHIFT on the first shift cycle. SC_SHIFT goes to SC_FULL when a shift would go past the longest legal scan. Both SC_SHIFT and SC_FULL return to SC_IDLE on `update_en`, and `update_en` takes priority over `shift_en`.

Top module: `dbg_cmd_decoder`

## Requirements
- R1: After reset no module is selected (`mod_valid`=0), every internal-register index is 0, all strobes are low and `tdo` is 0.
- R2: A 3-bit scan whose last bit is 1 selects the module given by its two low bits (0 system bus, 1 and 2 CPU ports, 3 serial port). It raises no strobe, and it takes effect even when a module is already selected.
- R3: A scan whose last bit is 1 but whose length is not 3 bits changes nothing.
- R4: A 6-bit command scan (last bit 0, opcode 0xD in bits [4:1], index in bit 0) sets the selected module's register index, pulses `ireg_sel_stb`, and leaves the other modules' indices unchanged.
- R5: A scan of 6+n bits (1 ≤ n ≤ 32) with opcode 0x9 in bits [n+4:n+1] pulses `ireg_wr_stb`. It presents bit n as `ireg_wr_idx` and bits [n-1:0], zero-extended, as `ireg_wr_data`.
- R6: A 53-bit scan has the word count in bits [15:0], the start address in bits [47:16], the opcode in bits [51:48] and 0 in bit 52. Opcodes 0x1/0x2/0x3 pulse `burst_wr_stb` and opcodes 0x5/0x6/0x7 pulse `burst_rd_stb`. `burst_size` is 0 for 8-bit words, 1 for 16-bit words and 2 for 32-bit words.
- R7: Module 0 accepts opcodes 0x0, 0x1–0x3, 0x5–0x7, 0x9 and 0xD. Modules 1 and 2 accept only 0x0, 0x3, 0x7, 0x9 and 0xD. Module 3 accepts none.
- R8: An opcode that is unknown or not accepted by the module, a command with the wrong length for its opcode, and any command before a module is selected all produce no strobe and change no state.
- R9: A 5-bit scan with opcode 0x0 (read) loads `rd_data`. On the next scan, `tdo` shows bit i of that value before the i-th shift edge.
- R10: Each strobe is high for exactly the one cycle after the `update_en` edge, and at most one strobe is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | Shift one bit from tdi this cycle |
| update_en | input | 1 | End of scan; decode the shifted bits |
| tdi | input | 1 | Serial scan data in, LSB first |
| rd_data | input | 33 | Contents of the selected internal register, captured on a read command |
| tdo | output | 1 | Serial read-back data out |
| mod_valid | output | 1 | A module has been selected |
| mod_sel | output | 2 | Selected module number |
| reg_idx | output | 1 | Internal-register index of the selected module |
| ireg_sel_stb | output | 1 | Internal-register select strobe |
| ireg_wr_stb | output | 1 | Internal-register write strobe |
| ireg_wr_idx | output | 1 | Register index carried by the write scan |
| ireg_wr_data | output | 32 | Write payload, zero-extended |
| burst_rd_stb | output | 1 | Start a burst read |
| burst_wr_stb | output | 1 | Start a burst write |
| burst_size | output | 2 | Word size: 0 byte, 1 halfword, 2 word |
| burst_addr | output | 32 | Burst start address |
| burst_words | output | 16 | Burst length in words |

## Verification
The bench builds the block with its default parameters. These are a 16-bit word count, a 32-bit address, a 1-bit register index and a 32-bit write payload, which give a 53-bit longest scan. With only four modules and sixteen opcodes, every module/opcode pair can be driven both as a full burst scan and as a short register-select scan. The expected strobes and fields are computed from the acceptance table. Payload lengths of 1, 2 and 32 bits, off-by-one scan lengths and a full 33-bit read-back complete the sweep.

// File: rtl/dbgdec_pkg.sv
package dbgdec_pkg;

    localparam int OPC_W = 4;
    localparam int MOD_W = 2;
    localparam int NUM_MOD = 1 << MOD_W;

    localparam logic [OPC_W-1:0] OPC_NOP    = 4'h0;
    localparam logic [OPC_W-1:0] OPC_WR8    = 4'h1;
    localparam logic [OPC_W-1:0] OPC_WR16   = 4'h2;
    localparam logic [OPC_W-1:0] OPC_WR32   = 4'h3;
    localparam logic [OPC_W-1:0] OPC_RD8    = 4'h5;
    localparam logic [OPC_W-1:0] OPC_RD16   = 4'h6;
    localparam logic [OPC_W-1:0] OPC_RD32   = 4'h7;
    localparam logic [OPC_W-1:0] OPC_REGWR  = 4'h9;
    localparam logic [OPC_W-1:0] OPC_REGSEL = 4'hD;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } wsize_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_MODSEL,
        ACT_REGSEL,
        ACT_REGWR,
        ACT_READ,
        ACT_BRD,
        ACT_BWR
    } act_e;

    // Opcode acceptance per module: bus module takes all sizes,
    // CPU ports take 32-bit bursts only, serial port takes nothing.
    function automatic logic op_legal(input logic [MOD_W-1:0] m,
                                      input logic [OPC_W-1:0] op);
        logic ok;
        ok = 1'b0;
        case (m)
            2'd0: ok = (op == OPC_NOP)  || (op == OPC_WR8)  || (op == OPC_WR16) ||
                       (op == OPC_WR32) || (op == OPC_RD8)  || (op == OPC_RD16) ||
                       (op == OPC_RD32) || (op == OPC_REGWR) || (op == OPC_REGSEL);
            2'd1, 2'd2: ok = (op == OPC_NOP) || (op == OPC_WR32) || (op == OPC_RD32) ||
                             (op == OPC_REGWR) || (op == OPC_REGSEL);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic wsize_e op_size(input logic [OPC_W-1:0] op);
        wsize_e s;
        case (op[1:0])
            2'd1:    s = SZ_BYTE;
            2'd2:    s = SZ_HALF;
            default: s = SZ_WORD;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dbgdec_scan.sv
module dbgdec_scan #(
    parameter int SR_W = 53,
    parameter int CW   = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            update_en,
    input  logic            tdi,
    output logic [SR_W-1:0] sr,
    output logic [CW-1:0]   cnt,
    output logic            overrun
);

    typedef enum logic [1:0] {
        SC_IDLE,
        SC_SHIFT,
        SC_FULL
    } scan_st_e;

    localparam logic [CW-1:0] L_MAX = CW'(SR_W);

    scan_st_e st, st_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SC_IDLE;
        else        st <= st_nxt;
    end

    // Next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            SC_IDLE: begin
                if (shift_en && !update_en) st_nxt = SC_SHIFT;
            end
            SC_SHIFT: begin
                if (update_en)                        st_nxt = SC_IDLE;
                else if (shift_en && (cnt == L_MAX))  st_nxt = SC_FULL;
            end
            SC_FULL: begin
                if (update_en) st_nxt = SC_IDLE;
            end
            default: st_nxt = SC_IDLE;
        endcase
    end

    // Shift register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr  <= '0;
            cnt <= '0;
        end else if (update_en) begin
            cnt <= '0;
        end else if (shift_en) begin
            sr <= {tdi, sr[SR_W-1:1]};
            if (st != SC_FULL) cnt <= cnt + 1'b1;
        end
    end

    assign overrun = (st == SC_FULL);

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !update_en && st != SC_FULL) |=> (cnt == $past(cnt) + 1'b1));

    // R8
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update_en |=> (cnt == '0));

endmodule

// File: rtl/dbgdec_classify.sv
module dbgdec_classify
    import dbgdec_pkg::*;
#(
    parameter int SR_W    = 53,
    parameter int CW      = 6,
    parameter int WORDS_W = 16,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 1,
    parameter int WDATA_W = 32
) (
    input  logic [SR_W-1:0]    sr,
    input  logic [CW-1:0]      cnt,
    input  logic               overrun,
    input  logic               mod_valid,
    input  logic [MOD_W-1:0]   cur_mod,
    output act_e               act,
    output logic [MOD_W-1:0]   new_mod,
    output logic [IDX_W-1:0]   scan_idx,
    output logic [WDATA_W-1:0] wdata,
    output logic [ADDR_W-1:0]  baddr,
    output logic [WORDS_W-1:0] bwords,
    output wsize_e             bsize
);

    localparam int SEL_LEN    = 1 + MOD_W;
    localparam int READ_LEN   = 1 + OPC_W;
    localparam int REGSEL_LEN = 1 + OPC_W + IDX_W;
    localparam int REGWR_MAX  = REGSEL_LEN + WDATA_W;
    localparam int BURST_LEN  = 1 + OPC_W + ADDR_W + WORDS_W;

    localparam logic [CW-1:0] L_SR     = CW'(SR_W);
    localparam logic [CW-1:0] L_SEL    = CW'(SEL_LEN);
    localparam logic [CW-1:0] L_READ   = CW'(READ_LEN);
    localparam logic [CW-1:0] L_REGSEL = CW'(REGSEL_LEN);
    localparam logic [CW-1:0] L_REGWR  = CW'(REGWR_MAX);
    localparam logic [CW-1:0] L_BURST  = CW'(BURST_LEN);

    logic              msb;
    logic [OPC_W-1:0]  op;
    logic [SR_W-1:0]   aligned;
    logic [SR_W-1:0]   above;
    logic [SR_W-1:0]   wmask;
    logic [SR_W-1:0]   masked;
    logic [CW-1:0]     payload_n;
    logic              is_regwr_len;

    assign msb = sr[SR_W-1];
    assign op  = sr[SR_W-2 -: OPC_W];

    // Right-justify the scan so bit 0 of the scan is bit 0 here
    always_comb begin
        if (cnt <= L_SR) aligned = sr >> (L_SR - cnt);
        else             aligned = sr;
    end

    assign payload_n    = cnt - L_REGSEL;
    assign is_regwr_len = (cnt > L_REGSEL) && (cnt <= L_REGWR);
    assign above        = aligned >> payload_n;
    assign wmask        = ~({SR_W{1'b1}} << payload_n);
    assign masked       = aligned & wmask;

    // Classification
    always_comb begin
        act = ACT_NONE;
        if (overrun) begin
            act = ACT_NONE;
        end else if (msb) begin
            if (cnt == L_SEL) act = ACT_MODSEL;
        end else if (mod_valid && op_legal(cur_mod, op)) begin
            case (op)
                OPC_NOP:    if (cnt == L_READ)   act = ACT_READ;
                OPC_REGSEL: if (cnt == L_REGSEL) act = ACT_REGSEL;
                OPC_REGWR:  if (is_regwr_len)    act = ACT_REGWR;
                OPC_WR8, OPC_WR16, OPC_WR32:
                            if (cnt == L_BURST)  act = ACT_BWR;
                OPC_RD8, OPC_RD16, OPC_RD32:
                            if (cnt == L_BURST)  act = ACT_BRD;
                default:    act = ACT_NONE;
            endcase
        end
    end

    assign new_mod  = aligned[MOD_W-1:0];
    assign scan_idx = (act == ACT_REGWR) ? above[IDX_W-1:0] : aligned[IDX_W-1:0];
    assign wdata    = masked[WDATA_W-1:0];
    assign bwords   = aligned[WORDS_W-1:0];
    assign baddr    = aligned[WORDS_W +: ADDR_W];
    assign bsize    = op_size(op);

endmodule

// File: rtl/dbgdec_ctx.sv
module dbgdec_ctx
    import dbgdec_pkg::*;
#(
    parameter int WORDS_W = 16,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 1,
    parameter int WDATA_W = 32,
    parameter int RD_W    = 33
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               update_en,
    input  act_e               act,
    input  logic [MOD_W-1:0]   new_mod,
    input  logic [IDX_W-1:0]   scan_idx,
    input  logic [WDATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0]  baddr,
    input  logic [WORDS_W-1:0] bwords,
    input  wsize_e             bsize,
    input  logic [RD_W-1:0]    rd_data,
    output logic               mod_valid,
    output logic [MOD_W-1:0]   cur_mod,
    output logic [IDX_W-1:0]   reg_idx,
    output logic               ireg_sel_stb,
    output logic               ireg_wr_stb,
    output logic [IDX_W-1:0]   ireg_wr_idx,
    output logic [WDATA_W-1:0] ireg_wr_data,
    output logic               burst_rd_stb,
    output logic               burst_wr_stb,
    output wsize_e             burst_size,
    output logic [ADDR_W-1:0]  burst_addr,
    output logic [WORDS_W-1:0] burst_words,
    output logic               tdo
);

    logic [IDX_W-1:0] idx_q [NUM_MOD];
    logic [RD_W-1:0]  rb_q;
    logic             any_stb;

    // Active module
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_valid <= 1'b0;
            cur_mod   <= '0;
        end else if (update_en && act == ACT_MODSEL) begin
            mod_valid <= 1'b1;
            cur_mod   <= new_mod;
        end
    end

    // Per-module register index
    for (genvar m = 0; m < NUM_MOD; m++) begin : g_idx
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                idx_q[m] <= '0;
            else if (update_en && act == ACT_REGSEL && cur_mod == MOD_W'(m))
                idx_q[m] <= scan_idx;
        end

        // R4
        idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(mod_valid && cur_mod == MOD_W'(m)) |=> $stable(idx_q[m]));
    end

    assign reg_idx = idx_q[cur_mod];

    // Strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ireg_sel_stb <= 1'b0;
            ireg_wr_stb  <= 1'b0;
            burst_rd_stb <= 1'b0;
            burst_wr_stb <= 1'b0;
        end else begin
            ireg_sel_stb <= update_en && (act == ACT_REGSEL);
            ireg_wr_stb  <= update_en && (act == ACT_REGWR);
            burst_rd_stb <= update_en && (act == ACT_BRD);
            burst_wr_stb <= update_en && (act == ACT_BWR);
        end
    end

    // Command fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ireg_wr_idx  <= '0;
            ireg_wr_data <= '0;
            burst_size   <= SZ_BYTE;
            burst_addr   <= '0;
            burst_words  <= '0;
        end else if (update_en) begin
            if (act == ACT_REGWR) begin
                ireg_wr_idx  <= scan_idx;
                ireg_wr_data <= wdata;
            end
            if (act == ACT_BRD || act == ACT_BWR) begin
                burst_size  <= bsize;
                burst_addr  <= baddr;
                burst_words <= bwords;
            end
        end
    end

    // Read-back shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              rb_q <= '0;
        else if (update_en && act == ACT_READ)   rb_q <= rd_data;
        else if (shift_en)                       rb_q <= rb_q >> 1;
    end

    assign tdo     = rb_q[0];
    assign any_stb = ireg_sel_stb | ireg_wr_stb | burst_rd_stb | burst_wr_stb;

    // R10
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ireg_sel_stb, ireg_wr_stb, burst_rd_stb, burst_wr_stb}));

    // R10
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |=> !any_stb);

    // R8
    no_module_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_valid |-> !any_stb);

    // R7
    cpu_word_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((burst_rd_stb || burst_wr_stb) && cur_mod != '0) |-> (burst_size == SZ_WORD));

    // R2
    modsel_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (update_en && act == ACT_MODSEL) |=> (mod_valid && cur_mod == $past(new_mod)));

endmodule

// File: rtl/dbg_cmd_decoder.sv
module dbg_cmd_decoder
    import dbgdec_pkg::*;
#(
    parameter int WORDS_W = 16,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 1,
    parameter int WDATA_W = 32,
    parameter int RD_W    = 33
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               update_en,
    input  logic               tdi,
    input  logic [RD_W-1:0]    rd_data,
    output logic               tdo,
    output logic               mod_valid,
    output logic [MOD_W-1:0]   mod_sel,
    output logic [IDX_W-1:0]   reg_idx,
    output logic               ireg_sel_stb,
    output logic               ireg_wr_stb,
    output logic [IDX_W-1:0]   ireg_wr_idx,
    output logic [WDATA_W-1:0] ireg_wr_data,
    output logic               burst_rd_stb,
    output logic               burst_wr_stb,
    output logic [1:0]         burst_size,
    output logic [ADDR_W-1:0]  burst_addr,
    output logic [WORDS_W-1:0] burst_words
);

    localparam int BURST_LEN = 1 + OPC_W + ADDR_W + WORDS_W;
    localparam int REGWR_MAX = 1 + OPC_W + IDX_W + WDATA_W;
    localparam int SR_W      = (BURST_LEN > REGWR_MAX) ? BURST_LEN : REGWR_MAX;
    localparam int CW        = $clog2(SR_W + 2);

    logic [SR_W-1:0]    sr;
    logic [CW-1:0]      cnt;
    logic               overrun;
    act_e               act;
    logic [MOD_W-1:0]   new_mod;
    logic [IDX_W-1:0]   scan_idx;
    logic [WDATA_W-1:0] wdata;
    logic [ADDR_W-1:0]  baddr;
    logic [WORDS_W-1:0] bwords;
    wsize_e             bsize;
    wsize_e             bsize_q;

    dbgdec_scan #(.SR_W(SR_W), .CW(CW)) u_scan (
        .clk       (tck),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .update_en (update_en),
        .tdi       (tdi),
        .sr        (sr),
        .cnt       (cnt),
        .overrun   (overrun)
    );

    dbgdec_classify #(
        .SR_W(SR_W), .CW(CW), .WORDS_W(WORDS_W), .ADDR_W(ADDR_W),
        .IDX_W(IDX_W), .WDATA_W(WDATA_W)
    ) u_cls (
        .sr        (sr),
        .cnt       (cnt),
        .overrun   (overrun),
        .mod_valid (mod_valid),
        .cur_mod   (mod_sel),
        .act       (act),
        .new_mod   (new_mod),
        .scan_idx  (scan_idx),
        .wdata     (wdata),
        .baddr     (baddr),
        .bwords    (bwords),
        .bsize     (bsize)
    );

    dbgdec_ctx #(
        .WORDS_W(WORDS_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
        .WDATA_W(WDATA_W), .RD_W(RD_W)
    ) u_ctx (
        .clk          (tck),
        .rst_n        (rst_n),
        .shift_en     (shift_en),
        .update_en    (update_en),
        .act          (act),
        .new_mod      (new_mod),
        .scan_idx     (scan_idx),
        .wdata        (wdata),
        .baddr        (baddr),
        .bwords       (bwords),
        .bsize        (bsize),
        .rd_data      (rd_data),
        .mod_valid    (mod_valid),
        .cur_mod      (mod_sel),
        .reg_idx      (reg_idx),
        .ireg_sel_stb (ireg_sel_stb),
        .ireg_wr_stb  (ireg_wr_stb),
        .ireg_wr_idx  (ireg_wr_idx),
        .ireg_wr_data (ireg_wr_data),
        .burst_rd_stb (burst_rd_stb),
        .burst_wr_stb (burst_wr_stb),
        .burst_size   (bsize_q),
        .burst_addr   (burst_addr),
        .burst_words  (burst_words),
        .tdo          (tdo)
    );

    assign burst_size = bsize_q;

endmodule

// File: tb/sim_dbg_cmd_decoder.sv
module sim_dbg_cmd_decoder;

    logic        tck = 1'b0;
    logic        rst_n = 1'b0;
    logic        shift_en = 1'b0;
    logic        update_en = 1'b0;
    logic        tdi = 1'b0;
    logic [32:0] rd_data = '0;
    logic        tdo;
    logic        mod_valid;
    logic [1:0]  mod_sel;
    logic [0:0]  reg_idx;
    logic        ireg_sel_stb;
    logic        ireg_wr_stb;
    logic [0:0]  ireg_wr_idx;
    logic [31:0] ireg_wr_data;
    logic        burst_rd_stb;
    logic        burst_wr_stb;
    logic [1:0]  burst_size;
    logic [31:0] burst_addr;
    logic [15:0] burst_words;

    int n_chk = 0;
    int n_fail = 0;

    always #10 tck = ~tck;

    dbg_cmd_decoder u0 (
        .tck(tck), .rst_n(rst_n), .shift_en(shift_en), .update_en(update_en),
        .tdi(tdi), .rd_data(rd_data), .tdo(tdo), .mod_valid(mod_valid),
        .mod_sel(mod_sel), .reg_idx(reg_idx), .ireg_sel_stb(ireg_sel_stb),
        .ireg_wr_stb(ireg_wr_stb), .ireg_wr_idx(ireg_wr_idx),
        .ireg_wr_data(ireg_wr_data), .burst_rd_stb(burst_rd_stb),
        .burst_wr_stb(burst_wr_stb), .burst_size(burst_size),
        .burst_addr(burst_addr), .burst_words(burst_words)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic scan(input logic [63:0] bits, input int n, output logic [63:0] got);
        got = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge tck);
            shift_en = 1'b1;
            tdi = bits[i];
            got[i] = tdo;
        end
        @(negedge tck);
        shift_en = 1'b0;
        tdi = 1'b0;
        update_en = 1'b1;
        @(negedge tck);
        update_en = 1'b0;
    endtask

    function automatic bit legal(input int m, input int op);
        if (m == 3) return 1'b0;
        if (m == 0)
            return (op == 0) || (op == 9) || (op == 13) ||
                   (op >= 1 && op <= 3) || (op >= 5 && op <= 7);
        return (op == 0) || (op == 3) || (op == 7) || (op == 9) || (op == 13);
    endfunction

    function automatic logic [3:0] stbs();
        return {burst_rd_stb, burst_wr_stb, ireg_sel_stb, ireg_wr_stb};
    endfunction

    task automatic sel_mod(input int m);
        logic [63:0] g;
        scan(64'(4 | m), 3, g);
    endtask

    function automatic logic [63:0] burst_bits(input int op, input logic [31:0] a,
                                               input logic [15:0] w);
        return {11'b0, 1'b0, 4'(op), a, w};
    endfunction

    function automatic logic [63:0] regwr_bits(input int n, input bit idx,
                                               input logic [31:0] d);
        logic [63:0] v;
        v = 64'(d) & ((64'd1 << n) - 1);
        v = v | (64'(idx) << n) | (64'd9 << (n + 1));
        return v;
    endfunction

    initial begin
        logic [63:0] g;
        logic [3:0]  e;
        logic [31:0] a;
        logic [15:0] w;
        repeat (3) @(negedge tck);
        rst_n = 1'b1;
        @(negedge tck);

        // R1 reset state
        check(mod_valid == 1'b0, "R1 mod_valid", 64'(mod_valid), 0);
        check(stbs() == 4'b0 && tdo == 1'b0, "R1 strobes/tdo", 64'({stbs(), tdo}), 0);
        check(reg_idx == 1'b0, "R1 reg_idx", 64'(reg_idx), 0);

        // R8 command before any selection
        scan(burst_bits(3, 32'h40, 16'h2), 53, g);
        check(stbs() == 4'b0, "R8 no module selected", 64'(stbs()), 0);
        scan(64'h1B, 6, g);
        check(stbs() == 4'b0 && mod_valid == 1'b0, "R8 regsel before select",
              64'({stbs(), mod_valid}), 0);

        // Sweep every module and opcode
        for (int m = 0; m < 4; m++) begin
            sel_mod(m);
            check(stbs() == 4'b0, "R2 select gives no strobe", 64'(stbs()), 0);
            check(mod_valid && mod_sel == 2'(m), "R2 module select",
                  64'({mod_valid, mod_sel}), 64'(4 | m));
            for (int op = 0; op < 16; op++) begin
                a = 32'h1000_0000 + 32'(m * 256) + 32'(op * 4);
                w = 16'h0100 + 16'(op) + 16'(m * 16);
                scan(burst_bits(op, a, w), 53, g);
                e = 4'b0;
                if (legal(m, op) && op >= 5 && op <= 7) e[3] = 1'b1;
                if (legal(m, op) && op >= 1 && op <= 3) e[2] = 1'b1;
                check(stbs() == e, $sformatf("R6/R7 burst m%0d op%0d", m, op),
                      64'(stbs()), 64'(e));
                if (e != 4'b0) begin
                    check(burst_addr == a && burst_words == w, "R6 burst fields",
                          {burst_addr, 16'b0, burst_words}, {a, 16'b0, w});
                    check(burst_size == 2'((op % 4) - 1), "R6 burst size",
                          64'(burst_size), 64'((op % 4) - 1));
                end
                @(negedge tck);
                check(stbs() == 4'b0, "R10 one-cycle strobe", 64'(stbs()), 0);

                scan({58'b0, 1'b0, 4'(op), 1'b1}, 6, g);
                e = (legal(m, op) && op == 13) ? 4'b0010 : 4'b0000;
                check(stbs() == e, $sformatf("R4/R8 short scan m%0d op%0d", m, op),
                      64'(stbs()), 64'(e));
                check(reg_idx == 1'(e[1]), "R4 index set", 64'(reg_idx), 64'(e[1]));
                scan(64'h1A, 6, g);
                check(reg_idx == 1'b0, "R4 index cleared", 64'(reg_idx), 0);
            end
        end

        // R4 index kept per module
        sel_mod(1);
        scan(64'h1B, 6, g);
        sel_mod(2);
        check(reg_idx == 1'b0, "R4 other module untouched", 64'(reg_idx), 0);
        sel_mod(1);
        check(reg_idx == 1'b1, "R4 index retained", 64'(reg_idx), 1);

        // R3 select with wrong length
        scan(64'h0E, 4, g);
        check(mod_sel == 2'd1 && stbs() == 4'b0, "R3 4-bit select ignored",
              64'(mod_sel), 1);
        scan(64'h03, 2, g);
        check(mod_sel == 2'd1, "R3 2-bit select ignored", 64'(mod_sel), 1);
        sel_mod(1);
        check(mod_sel == 2'd1 && mod_valid, "R2 reselect same module", 64'(mod_sel), 1);

        // R5 register writes
        sel_mod(0);
        scan(regwr_bits(1, 1'b0, 32'h1), 7, g);
        check(ireg_wr_stb && ireg_wr_idx == 1'b0 && ireg_wr_data == 32'h1,
              "R5 1-bit write", {ireg_wr_stb, ireg_wr_idx, ireg_wr_data}, 64'h2_0000_0001);
        scan(regwr_bits(32, 1'b1, 32'hA5C3_0F96), 38, g);
        check(ireg_wr_stb && ireg_wr_idx == 1'b1 && ireg_wr_data == 32'hA5C3_0F96,
              "R5 32-bit write", {ireg_wr_stb, ireg_wr_idx, ireg_wr_data},
              64'h3_A5C3_0F96);
        sel_mod(2);
        scan(regwr_bits(2, 1'b1, 32'h2), 8, g);
        check(ireg_wr_stb && ireg_wr_idx == 1'b1 && ireg_wr_data == 32'h2,
              "R5 2-bit write on CPU port", {ireg_wr_stb, ireg_wr_idx, ireg_wr_data},
              64'h3_0000_0002);
        scan(64'h12, 6, g);
        check(stbs() == 4'b0, "R8 write with no payload", 64'(stbs()), 0);

        // R8 burst with wrong length
        sel_mod(0);
        scan(burst_bits(7, 32'h55, 16'h3) & 64'h000F_FFFF_FFFF_FFFF, 52, g);
        check(stbs() == 4'b0, "R8 52-bit burst ignored", 64'(stbs()), 0);
        scan(burst_bits(7, 32'h55, 16'h3), 60, g);
        check(stbs() == 4'b0, "R8 overlong scan ignored", 64'(stbs()), 0);

        // R9 read-back
        rd_data = 33'h1_3579_BDF1;
        scan(64'h0, 5, g);
        check(stbs() == 4'b0, "R9 read gives no strobe", 64'(stbs()), 0);
        rd_data = '0;
        scan(64'h0, 33, g);
        check(g[32:0] == 33'h1_3579_BDF1, "R9 tdo read-back", 64'(g[32:0]),
              64'h1_3579_BDF1);
        sel_mod(3);
        rd_data = 33'h0_FFFF_FFFF;
        scan(64'h0, 5, g);
        scan(64'h0, 8, g);
        check(g[7:0] == 8'h00, "R8 read on module 3 ignored", 64'(g[7:0]), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge tck);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule